// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the processor's side of taking an interrupt. It watches the pending interrupt level and the mask field of the status register. When the request is allowed through, it moves the core into supervisor state with tracing switched off. It then fetches the vector number with a byte-wide acknowledge read and pushes a two-longword exception frame below the stack pointer. After that it raises the mask to the accepted level, reads the handler address from the vector table, and hands that address to the fetch unit as the new PC.

All memory traffic goes through one 32-bit request/ready port. Every access holds its request until the ready input is seen high at a clock edge. After an entry completes, the block stays deaf to further requests until the core signals that the first handler instruction has retired. This gives the handler one instruction in which it can close the mask safely.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry starts only when the pending level (3 bits) is strictly greater than the status mask field (status bits 10:8), or when the pending level is 7, which is accepted at any mask. Level 0 never starts an entry.
- R2: The first action of an entry is a status write, made before any memory request. This write sets bit 13 (supervisor), clears bit 15 (trace), and keeps every other bit of the status value captured at acceptance.
- R3: The vector is fetched by a read with the acknowledge flag high and size code 0 (byte). Its address is all ones except bits 4:2, which hold the level, and bits 1:0, which are zero. Only read data bits 7:0 are used as the vector.
- R4: The frame is written as two longword writes (size code 2). The PC is written first, at SP-4. The status longword is written second, at SP-8. The status longword holds zero in bits 31:24, the vector in bits 23:16 and the captured status value in bits 15:0.
- R5: After both frame writes, and in the same cycle, the block writes the status register with the mask field set to the accepted level (bit 13 set, bit 15 clear) and writes SP-8 to the stack pointer.
- R6: After the mask update, one longword read is made from the vector base plus four times the vector.
- R7: The word returned by the vector-table read is output as the new PC in a single-cycle strobe. In the next cycle the block is idle.
- R8: While a request waits for ready, its address, direction and size stay unchanged.
- R9: After an entry, no new entry starts until the retire input has been high at a clock edge. If retire and a qualifying request are present in the same cycle, the new entry begins one cycle later.
- R10: During and right after reset there is no memory request, no register write strobe, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level_i | input | 3 | Highest pending interrupt level |
| sr_i | input | 16 | Current status register |
| pc_i | input | 32 | PC of the interrupted instruction |
| sp_i | input | 32 | Current stack pointer |
| vbr_i | input | 32 | Vector table base address |
| retire_i | input | 1 | An instruction retired this cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_ack_o | output | 1 | Request is an interrupt acknowledge read |
| mem_size_o | output | 2 | Size code: 0 byte, 2 longword |
| mem_addr_o | output | 32 | Request address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes at this edge |
| sr_we_o | output | 1 | Status register write strobe |
| sr_o | output | 16 | Status register write value |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_o | output | 32 | Stack pointer write value |
| pc_we_o | output | 1 | New PC strobe |
| pc_o | output | 32 | Handler address |
| busy_o | output | 1 | Entry in progress |

## Verification
Two events can meet in one cycle: the release of the post-entry block by a retire pulse, and a qualifying request from the sampling logic. The bench holds level 7 pending after an entry and keeps retire low to show that nothing starts. It then raises retire for exactly one cycle while the request is still present. The outcome is judged by requiring busy to be low at the first sampling point after that edge and high at the next one, which shows that the release and the new acceptance are one edge apart.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int XLEN        = 32;
  localparam int SR_W        = 16;
  localparam int LVL_W       = 3;
  localparam int VEC_W       = 8;
  localparam int SR_S_BIT    = 13;
  localparam int SR_T_BIT    = 15;
  localparam int SR_MASK_LSB = 8;
  localparam int WORD_BYTES  = 4;
  localparam int ACK_LVL_LSB = 2;

  localparam logic [LVL_W-1:0] LVL_TOP = '1;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_LONG = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SUPV, ST_IACK, ST_PUSH_PC,
    ST_PUSH_SR, ST_MASK, ST_VEC, ST_JUMP
  } ent_state_e;

  function automatic logic level_wins(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] mask);
    return (lvl == LVL_TOP) || (lvl > mask);
  endfunction

  function automatic logic [SR_W-1:0] sr_enter(input logic [SR_W-1:0] sr);
    logic [SR_W-1:0] r;
    r = sr;
    r[SR_S_BIT] = 1'b1;
    r[SR_T_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [SR_W-1:0] sr_with_mask(input logic [SR_W-1:0] sr,
                                                   input logic [LVL_W-1:0] lvl);
    logic [SR_W-1:0] r;
    r = sr;
    r[SR_MASK_LSB +: LVL_W] = lvl;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] status_word(input logic [VEC_W-1:0] vec,
                                                  input logic [SR_W-1:0] sr);
    logic [XLEN-1:0] w;
    w = '0;
    w[SR_W +: VEC_W] = vec;
    w[SR_W-1:0] = sr;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] ack_address(input logic [LVL_W-1:0] lvl);
    logic [XLEN-1:0] a;
    a = '1;
    a[ACK_LVL_LSB +: LVL_W] = lvl;
    a[ACK_LVL_LSB-1:0] = '0;
    return a;
  endfunction

  function automatic logic [XLEN-1:0] frame_slot(input logic [XLEN-1:0] sp,
                                                 input int unsigned nwords);
    return sp - XLEN'(WORD_BYTES * nwords);
  endfunction

  function automatic logic [XLEN-1:0] table_slot(input logic [XLEN-1:0] base,
                                                 input logic [VEC_W-1:0] vec);
    return base + (XLEN'(vec) * XLEN'(WORD_BYTES));
  endfunction
endpackage

// File: rtl/irq_take_gate.sv
module irq_take_gate
  import irq_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             idle_i,
  input  logic             entry_done_i,
  input  logic             retire_i,
  output logic             take_o,
  output logic             blocked_o
);
  logic blocked_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            blocked_q <= 1'b0;
    else if (entry_done_i) blocked_q <= 1'b1;
    else if (retire_i)     blocked_q <= 1'b0;
  end

  assign take_o    = idle_i && !blocked_q && level_wins(level_i, mask_i);
  assign blocked_o = blocked_q;
endmodule

// File: rtl/irq_entry_core.sv
module irq_entry_core
  import irq_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [SR_W-1:0]  sr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  vbr_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             mem_ack_o,
  output logic [1:0]       mem_size_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  output logic             sr_we_o,
  output logic [SR_W-1:0]  sr_o,
  output logic             sp_we_o,
  output logic [XLEN-1:0]  sp_o,
  output logic             pc_we_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             idle_o,
  output logic             entry_done_o
);
  ent_state_e state_q, state_d;
  logic [LVL_W-1:0] lvl_q;
  logic [SR_W-1:0]  sr_q;
  logic [XLEN-1:0]  pc_q, sp_q, vbr_q, handler_q;
  logic [VEC_W-1:0] vec_q;
  logic             access_done;

  assign access_done = mem_req_o && mem_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (take_i) state_d = ST_SUPV;
      ST_SUPV:    state_d = ST_IACK;
      ST_IACK:    if (access_done) state_d = ST_PUSH_PC;
      ST_PUSH_PC: if (access_done) state_d = ST_PUSH_SR;
      ST_PUSH_SR: if (access_done) state_d = ST_MASK;
      ST_MASK:    state_d = ST_VEC;
      ST_VEC:     if (access_done) state_d = ST_JUMP;
      ST_JUMP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lvl_q     <= '0;
      sr_q      <= '0;
      pc_q      <= '0;
      sp_q      <= '0;
      vbr_q     <= '0;
      vec_q     <= '0;
      handler_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && take_i) begin
        lvl_q <= level_i;
        sr_q  <= sr_i;
        pc_q  <= pc_i;
        sp_q  <= sp_i;
        vbr_q <= vbr_i;
      end
      if (state_q == ST_IACK && access_done) vec_q <= mem_rdata_i[VEC_W-1:0];
      if (state_q == ST_VEC && access_done)  handler_q <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_ack_o   = 1'b0;
    mem_size_o  = SZ_LONG;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_IACK: begin
        mem_req_o  = 1'b1;
        mem_ack_o  = 1'b1;
        mem_size_o = SZ_BYTE;
        mem_addr_o = ack_address(lvl_q);
      end
      ST_PUSH_PC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = frame_slot(sp_q, 1);
        mem_wdata_o = pc_q;
      end
      ST_PUSH_SR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = frame_slot(sp_q, 2);
        mem_wdata_o = status_word(vec_q, sr_q);
      end
      ST_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = table_slot(vbr_q, vec_q);
      end
      default: ;
    endcase
  end

  assign sr_we_o      = (state_q == ST_SUPV) || (state_q == ST_MASK);
  assign sr_o         = (state_q == ST_MASK) ? sr_with_mask(sr_enter(sr_q), lvl_q)
                                             : sr_enter(sr_q);
  assign sp_we_o      = (state_q == ST_MASK);
  assign sp_o         = frame_slot(sp_q, 2);
  assign pc_we_o      = (state_q == ST_JUMP);
  assign pc_o         = handler_q;
  assign idle_o       = (state_q == ST_IDLE);
  assign entry_done_o = (state_q == ST_JUMP);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  irq_level_i,
  input  logic [15:0] sr_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] sp_i,
  input  logic [31:0] vbr_i,
  input  logic        retire_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic        mem_ack_o,
  output logic [1:0]  mem_size_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i,
  output logic        sr_we_o,
  output logic [15:0] sr_o,
  output logic        sp_we_o,
  output logic [31:0] sp_o,
  output logic        pc_we_o,
  output logic [31:0] pc_o,
  output logic        busy_o
);
  logic take_w, blocked_w, idle_w, done_w;

  irq_take_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_i      (irq_level_i),
    .mask_i       (sr_i[SR_MASK_LSB +: LVL_W]),
    .idle_i       (idle_w),
    .entry_done_i (done_w),
    .retire_i     (retire_i),
    .take_o       (take_w),
    .blocked_o    (blocked_w)
  );

  irq_entry_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_i       (take_w),
    .level_i      (irq_level_i),
    .sr_i         (sr_i),
    .pc_i         (pc_i),
    .sp_i         (sp_i),
    .vbr_i        (vbr_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_ready_i  (mem_ready_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_ack_o    (mem_ack_o),
    .mem_size_o   (mem_size_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .sr_we_o      (sr_we_o),
    .sr_o         (sr_o),
    .sp_we_o      (sp_we_o),
    .sp_o         (sp_o),
    .pc_we_o      (pc_we_o),
    .pc_o         (pc_o),
    .idle_o       (idle_w),
    .entry_done_o (done_w)
  );

  assign busy_o = !idle_w;
endmodule

// File: rtl/irq_entry_checks.sv
module irq_entry_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  level,
  input logic [2:0]  mask,
  input logic        busy,
  input logic        blocked,
  input logic        mem_req,
  input logic        mem_ready,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [1:0]  mem_size,
  input logic [31:0] mem_addr,
  input logic        sr_we,
  input logic [15:0] sr_val,
  input logic        pc_we
);
  assert_accept_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(level) == 3'd7 || $past(level) > $past(mask)));

  assert_supv_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sr_we && sr_val[13] && !sr_val[15] && !mem_req));

  assert_ack_byte_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> (mem_req && !mem_we && mem_size == 2'd0));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_size)));

  assert_jump_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (!busy && blocked));

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> !$rose(busy));
endmodule

bind irq_entry_seq irq_entry_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .level     (irq_level_i),
  .mask      (sr_i[10:8]),
  .busy      (busy_o),
  .blocked   (blocked_w),
  .mem_req   (mem_req_o),
  .mem_ready (mem_ready_i),
  .mem_we    (mem_we_o),
  .mem_ack   (mem_ack_o),
  .mem_size  (mem_size_o),
  .mem_addr  (mem_addr_o),
  .sr_we     (sr_we_o),
  .sr_val    (sr_o),
  .pc_we     (pc_we_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] lvl;
    logic [2:0] mask;
    logic [1:0] wt;
    logic       take;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t ROWS [NROWS] = '{
    '{3'd5, 3'd2, 2'd0, 1'b1},
    '{3'd3, 3'd3, 2'd1, 1'b0},
    '{3'd7, 3'd7, 2'd2, 1'b1},
    '{3'd1, 3'd0, 2'd3, 1'b1},
    '{3'd0, 3'd0, 2'd0, 1'b0},
    '{3'd4, 3'd6, 2'd1, 1'b0},
    '{3'd6, 3'd5, 2'd0, 1'b1}
  };

  localparam logic [31:0] VBR = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  irq_level = '0;
  logic [15:0] sr = '0;
  logic [31:0] pc = '0, sp = '0;
  logic        retire = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        mem_req, mem_we, mem_ack, sr_we, sp_we, pc_we, busy;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, sp_out, pc_out;
  logic [15:0] sr_out;

  int n_checks = 0;
  int n_err = 0;
  int wait_cyc = 0;
  int acc_cnt = 0;

  int          ev_n = 0;
  int          ev_kind [16];
  logic [31:0] ev_a [16];
  logic [31:0] ev_d [16];
  logic [3:0]  ev_f [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_level_i(irq_level), .sr_i(sr),
    .pc_i(pc), .sp_i(sp), .vbr_i(VBR), .retire_i(retire),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_ack_o(mem_ack),
    .mem_size_o(mem_size), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .sr_we_o(sr_we), .sr_o(sr_out), .sp_we_o(sp_we), .sp_o(sp_out),
    .pc_we_o(pc_we), .pc_o(pc_out), .busy_o(busy)
  );

  function automatic logic [7:0] vec_of(input logic [2:0] lvl);
    return 8'd64 + 8'(lvl) * 8'd9;
  endfunction

  function automatic logic [31:0] handler_at(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic log_ev(input int k, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] f);
    if (ev_n < 16) begin
      ev_kind[ev_n] = k; ev_a[ev_n] = a; ev_d[ev_n] = d; ev_f[ev_n] = f;
    end
    ev_n++;
  endtask

  // memory model and event monitor, all at the falling edge
  always @(negedge clk) begin
    if (!mem_req) begin
      acc_cnt = 0;
      mem_ready = 1'b0;
      mem_rdata = '0;
    end else begin
      if (mem_ready) acc_cnt = 0;
      mem_ready = (acc_cnt == wait_cyc);
      mem_rdata = '0;
      if (mem_ready) begin
        if (mem_ack) mem_rdata = {24'hABCDEF, vec_of(mem_addr[4:2])};
        else if (!mem_we) mem_rdata = handler_at(mem_addr);
        log_ev(2, mem_addr, mem_we ? mem_wdata : 32'h0,
               {mem_we, mem_ack, mem_size});
      end
      acc_cnt++;
    end
    if (sr_we) log_ev(1, 32'h0, {16'h0, sr_out}, 4'h0);
    if (sp_we) log_ev(3, 32'h0, sp_out, 4'h0);
    if (pc_we) log_ev(4, 32'h0, pc_out, 4'h0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_ev(input int i, input int k, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] f, input string req);
    chk(ev_kind[i] == k, {req, " kind"}, 32'(ev_kind[i]), 32'(k));
    chk(ev_a[i] == a, {req, " addr"}, ev_a[i], a);
    chk(ev_d[i] == d, {req, " data"}, ev_d[i], d);
    chk(ev_f[i] == f, {req, " attr"}, 32'(ev_f[i]), 32'(f));
  endtask

  task automatic unblock();
    @(negedge clk); retire = 1'b1;
    @(negedge clk); retire = 1'b0;
  endtask

  task automatic run_row(input row_t r, input int i);
    logic [15:0] sr0, sr_e, sr_m;
    logic [31:0] pc0, sp0, tab;
    logic [7:0]  v;
    @(negedge clk);
    ev_n = 0;
    wait_cyc = int'(r.wt);
    sr0 = 16'h8000 | (16'(r.mask) << 8) | 16'(i);
    pc0 = 32'h0001_0000 + 32'(i) * 32'h100;
    sp0 = 32'h0002_0000 - 32'(i) * 32'h40;
    sr = sr0; pc = pc0; sp = sp0; irq_level = r.lvl;
    if (!r.take) begin
      repeat (20) @(negedge clk);
      // R1: level not above mask, or level 0: nothing happens at the ports
      chk(ev_n == 0 && !busy, "R1 no entry", 32'(ev_n), 32'h0);
      irq_level = '0;
      return;
    end
    for (int t = 0; t < 80 && ev_n < 8; t++) @(negedge clk);
    irq_level = '0;
    repeat (2) @(negedge clk);
    v    = vec_of(r.lvl);
    sr_e = (sr0 | 16'h2000) & 16'h7FFF;
    sr_m = (sr_e & 16'hF8FF) | (16'(r.lvl) << 8);
    tab  = VBR + {22'h0, v, 2'b00};
    chk(ev_n == 8, "R1 entry event count", 32'(ev_n), 32'd8);
    if (ev_n == 8) begin
      chk_ev(0, 1, 32'h0, {16'h0, sr_e}, 4'h0, "R2 supervisor write");
      chk_ev(1, 2, 32'hFFFF_FFE0 | (32'(r.lvl) << 2), 32'h0, 4'b0100, "R3 ack read R8");
      chk_ev(2, 2, sp0 - 32'd4, pc0, 4'b1010, "R4 pc push R8");
      chk_ev(3, 2, sp0 - 32'd8, {8'h00, v, sr0}, 4'b1010, "R4 status push R8");
      chk_ev(4, 1, 32'h0, {16'h0, sr_m}, 4'h0, "R5 mask write");
      chk_ev(5, 3, 32'h0, sp0 - 32'd8, 4'h0, "R5 sp write");
      chk_ev(6, 2, tab, 32'h0, 4'b0010, "R6 table read R8");
      chk_ev(7, 4, 32'h0, handler_at(tab), 4'h0, "R7 new pc");
    end
    chk(!busy, "R7 idle after jump", 32'(busy), 32'h0);
    unblock();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    irq_level = 3'd7;
    repeat (3) @(negedge clk);
    // R10: reset holds everything quiet even with level 7 pending
    chk(!mem_req && !sr_we && !sp_we && !pc_we && !busy, "R10 reset quiet",
        {28'h0, mem_req, sr_we, pc_we, busy}, 32'h0);
    irq_level = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R10 after reset", {30'h0, mem_req, busy}, 32'h0);

    for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i);

    // R9: block after entry, then simultaneous retire and request
    @(negedge clk);
    ev_n = 0; wait_cyc = 0;
    sr = 16'h2700; pc = 32'h0003_0000; sp = 32'h0004_0000; irq_level = 3'd7;
    for (int t = 0; t < 40 && ev_n < 8; t++) @(negedge clk);
    chk(ev_n == 8, "R9 first entry", 32'(ev_n), 32'd8);
    repeat (15) @(negedge clk);
    chk(ev_n == 8 && !busy, "R9 held off without retire", 32'(ev_n), 32'd8);
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    chk(!busy, "R9 not yet started at retire edge", 32'(busy), 32'h0);
    @(negedge clk);
    chk(busy, "R9 started one cycle later", 32'(busy), 32'h1);
    irq_level = '0;
    for (int t = 0; t < 40 && busy; t++) @(negedge clk);
    unblock();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule